// File: doc/BRIEF.md
# Seven-Slot LVDS Pixel Serializer

This block turns one parallel pixel per pixel period into bit streams for up to four LVDS data lanes and one clock lane. Each pixel period has seven bit slots. The block runs on the bit-rate clock, so one slot lasts one clock cycle. A pixel is 8-bit red, green and blue plus horizontal sync, vertical sync and data enable.

A two-bit map select chooses one of three slot layouts:

- an 18-bit layout on three lanes;
- a 24-bit layout that puts the two low bits of each colour on lane 3;
- a 24-bit layout that puts the two high bits of each colour on lane 3.

All three layouts share one slot counter and one clock-lane pattern.

The slot counter is a seven-state machine, SLOT0 to SLOT6. Each transition SLOTn to SLOTn+1 happens on every clock. The transition SLOT6 to SLOT0 is the wrap, and it marks the pixel boundary. On the wrap cycle the pixel and the map select are turned into seven-bit lane words and stored in a holding register. During the next period each lane sends the bit of its stored word that the current state selects. Input changes at other times therefore never split a pixel.

Top module: `lvds7_serializer`

## Requirements
- R1: Each pixel period is seven clock cycles, slot 0 to slot 6, and slot 0 is sent first. The slot counter moves forward by one every clock and returns from 6 to 0.
- R2: `lane_clk` is 1 in slots 0, 1, 5 and 6, and 0 in slots 2, 3 and 4.
- R3: With `map_sel` = 0, lanes 0 to 2 carry bits 7..2 of each colour as bits 5..0, in this order:
    - lane 0, slots 0 to 6: G[2], R[7], R[6], R[5], R[4], R[3], R[2];
    - lane 1: B[3], B[2], G[7], G[6], G[5], G[4], G[3];
    - lane 2, slots 3 to 6: B[7], B[6], B[5], B[4].
- R4: With `map_sel` = 1, lanes 0 to 2 are the same as in R3. Lane 3, slots 1 to 6, sends B[1], B[0], G[1], G[0], R[1], R[0].
- R5: With `map_sel` = 2, lanes 0 to 2 use the R3 positions with bits 5..0 of each colour (lane 0 is G[0], R[5]..R[0]; lane 1 is B[1], B[0], G[5]..G[1]; lane 2, slots 3 to 6, is B[5]..B[2]). Lane 3, slots 1 to 6, sends B[7], B[6], G[7], G[6], R[7], R[6].
- R6: In every mode, lane 2 sends data enable, vertical sync and horizontal sync in slots 0, 1 and 2. Lane 3 sends 0 in slot 0.
- R7: With `map_sel` = 0, or with the reserved value 3 (which maps like 0), lane 3 is held at 0 in every slot.
- R8: The pixel and `map_sel` are sampled only on the clock edge that takes the counter from slot 6 to slot 0. Changes at any other time, including changes of mode, do not affect the period being sent.
- R9: Synchronous reset puts the counter in slot 0, clears the held pixel and selects map 0. All data lanes are 0 until the first pixel sampled after reset is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, one slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| pix_hsync | input | 1 | Horizontal sync |
| pix_vsync | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable |
| map_sel | input | 2 | 0: 18-bit, 1: 24-bit low bits on lane 3, 2: 24-bit high bits on lane 3, 3: as 0 |
| lane_data | output | 4 | One serial bit per data lane, lane 0 at bit 0 |
| lane_clk | output | 1 | Clock lane pattern |

## Verification
Every lane is compared with an arithmetic model in every slot, for all four `map_sel` values. The pixels include random values, all ones and all zeros; the random values tell apart the bit order within each lane and the 6-bit offset of each mode. Another phase changes the pixel and the mode to noise in every slot except the wrap slot, which tells apart capture at the boundary from capture at any other time. Reset is applied both at start-up and in the middle of a pixel, which shows the held pixel is cleared and the clock phase restarts.

// File: rtl/lvds7_pkg.sv
`timescale 1ns/1ps
package lvds7_pkg;
    localparam int SLOTS  = 7;
    localparam int LANES  = 4;
    localparam int COMP_W = 8;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef enum logic [1:0] {
        MAP_18     = 2'd0,
        MAP_24_LOW = 2'd1,
        MAP_24_HI  = 2'd2,
        MAP_RSVD   = 2'd3
    } map_e;

    typedef enum logic [SLOT_W-1:0] {
        SLOT0 = 3'd0, SLOT1 = 3'd1, SLOT2 = 3'd2, SLOT3 = 3'd3,
        SLOT4 = 3'd4, SLOT5 = 3'd5, SLOT6 = 3'd6
    } slot_e;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
        logic              hs;
        logic              vs;
        logic              de;
    } pixel_t;

    typedef logic [LANES-1:0][SLOTS-1:0] lane_words_t;
endpackage

// File: rtl/lvds7_slot_fsm.sv
`timescale 1ns/1ps
module lvds7_slot_fsm
    import lvds7_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output slot_e slot,
    output logic  wrap,
    output logic  clk_lane
);
    slot_e slot_q;
    slot_e slot_d;

    always_ff @(posedge clk) begin
        if (rst) slot_q <= SLOT0;
        else     slot_q <= slot_d;
    end

    always_comb begin
        slot_d   = SLOT0;
        wrap     = 1'b0;
        clk_lane = 1'b1;
        unique case (slot_q)
            SLOT0: slot_d = SLOT1;
            SLOT1: slot_d = SLOT2;
            SLOT2: begin slot_d = SLOT3; clk_lane = 1'b0; end
            SLOT3: begin slot_d = SLOT4; clk_lane = 1'b0; end
            SLOT4: begin slot_d = SLOT5; clk_lane = 1'b0; end
            SLOT5: slot_d = SLOT6;
            SLOT6: begin slot_d = SLOT0; wrap = 1'b1; end
            default: slot_d = SLOT0;
        endcase
    end

    assign slot = slot_q;
endmodule

// File: rtl/lvds7_slot_map.sv
`timescale 1ns/1ps
module lvds7_slot_map
    import lvds7_pkg::*;
(
    input  pixel_t      px,
    input  logic [1:0]  sel,
    output lane_words_t words
);
    // Word bit index equals slot number; slot 0 leaves first.
    always_comb begin
        words = '0;
        unique case (map_e'(sel))
            MAP_24_HI: begin
                words[0] = {px.r[0], px.r[1], px.r[2], px.r[3], px.r[4], px.r[5], px.g[0]};
                words[1] = {px.g[1], px.g[2], px.g[3], px.g[4], px.g[5], px.b[0], px.b[1]};
                words[2] = {px.b[2], px.b[3], px.b[4], px.b[5], px.hs, px.vs, px.de};
                words[3] = {px.r[6], px.r[7], px.g[6], px.g[7], px.b[6], px.b[7], 1'b0};
            end
            MAP_24_LOW: begin
                words[0] = {px.r[2], px.r[3], px.r[4], px.r[5], px.r[6], px.r[7], px.g[2]};
                words[1] = {px.g[3], px.g[4], px.g[5], px.g[6], px.g[7], px.b[2], px.b[3]};
                words[2] = {px.b[4], px.b[5], px.b[6], px.b[7], px.hs, px.vs, px.de};
                words[3] = {px.r[0], px.r[1], px.g[0], px.g[1], px.b[0], px.b[1], 1'b0};
            end
            MAP_18, MAP_RSVD: begin
                words[0] = {px.r[2], px.r[3], px.r[4], px.r[5], px.r[6], px.r[7], px.g[2]};
                words[1] = {px.g[3], px.g[4], px.g[5], px.g[6], px.g[7], px.b[2], px.b[3]};
                words[2] = {px.b[4], px.b[5], px.b[6], px.b[7], px.hs, px.vs, px.de};
                words[3] = '0;
            end
            default: words = '0;
        endcase
    end
endmodule

// File: rtl/lvds7_hold.sv
`timescale 1ns/1ps
module lvds7_hold #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/lvds7_serializer.sv
`timescale 1ns/1ps
module lvds7_serializer
    import lvds7_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [COMP_W-1:0] pix_r,
    input  logic [COMP_W-1:0] pix_g,
    input  logic [COMP_W-1:0] pix_b,
    input  logic              pix_hsync,
    input  logic              pix_vsync,
    input  logic              pix_de,
    input  logic [1:0]        map_sel,
    output logic [LANES-1:0]  lane_data,
    output logic              lane_clk
);
    localparam int HOLD_W = LANES * SLOTS;

    slot_e       slot;
    logic        wrap;
    pixel_t      px;
    lane_words_t next_words;
    lane_words_t held_words;

    assign px = '{r: pix_r, g: pix_g, b: pix_b, hs: pix_hsync, vs: pix_vsync, de: pix_de};

    lvds7_slot_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .slot     (slot),
        .wrap     (wrap),
        .clk_lane (lane_clk)
    );

    lvds7_slot_map u_map (
        .px    (px),
        .sel   (map_sel),
        .words (next_words)
    );

    lvds7_hold #(.W(HOLD_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .load (wrap),
        .d    (next_words),
        .q    (held_words)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_data[l] = held_words[l][slot];
    end
endmodule

// File: rtl/lvds7_serializer_chk.sv
`timescale 1ns/1ps
module lvds7_serializer_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] map_sel,
    input logic [3:0] lane_data,
    input logic       lane_clk
);
    logic [2:0] cnt;
    logic [1:0] held_m;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= 3'd0;
            held_m <= 2'd0;
        end else begin
            cnt <= (cnt == 3'd6) ? 3'd0 : cnt + 3'd1;
            if (cnt == 3'd6) held_m <= map_sel;
        end
    end

    // R1, R2: framing pattern follows the cycle count since reset
    a_r2_clk_frame: assert property (@(posedge clk) disable iff (rst)
        lane_clk == ((cnt < 3'd2) || (cnt > 3'd4)));

    a_r6_ctl3_zero: assert property (@(posedge clk) disable iff (rst)
        (cnt == 3'd0) |-> !lane_data[3]);

    a_r7_lane3_idle: assert property (@(posedge clk) disable iff (rst)
        ((held_m == 2'd0) || (held_m == 2'd3)) |-> !lane_data[3]);

    a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lane_data == 4'd0) && lane_clk);
endmodule

bind lvds7_serializer lvds7_serializer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .map_sel   (map_sel),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
);

// File: tb/lvds7_serializer_tb.sv
`timescale 1ns/1ps
module lvds7_serializer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic       pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
    logic [1:0] map_sel = 2'd0;
    logic [3:0] lane_data;
    logic       lane_clk;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // model of the pixel currently being sent
    logic [7:0] h_r = '0, h_g = '0, h_b = '0;
    logic       h_hs = 1'b0, h_vs = 1'b0, h_de = 1'b0;
    logic [1:0] h_m = 2'd0;

    always #2.5 clk = ~clk;

    lvds7_serializer u_dut (
        .clk(clk), .rst(rst), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
        .map_sel(map_sel), .lane_data(lane_data), .lane_clk(lane_clk)
    );

    function automatic int eff_mode();
        return (h_m == 2'd3) ? 0 : int'(h_m);
    endfunction

    function automatic logic exp_bit(int l, int s);
        int m  = eff_mode();
        int sh = (m == 2) ? 0 : 2;
        int lo;
        case (l)
            0: return (s == 0) ? h_g[sh] : h_r[sh + 6 - s];
            1: return (s == 0) ? h_b[sh + 1] : (s == 1) ? h_b[sh] : h_g[sh + 7 - s];
            2: return (s == 0) ? h_de : (s == 1) ? h_vs : (s == 2) ? h_hs : h_b[sh + 8 - s];
            default: begin
                if (m == 0 || s == 0) return 1'b0;
                lo = ((m == 1) ? 0 : 6) + (s % 2);
                if (s <= 2)      return h_b[lo];
                else if (s <= 4) return h_g[lo];
                else             return h_r[lo];
            end
        endcase
    endfunction

    function automatic string lane_tag(int l, int s);
        int m = eff_mode();
        if (l == 2 && s < 3) return "R6";
        if (l == 3 && s == 0) return "R6";
        if (l == 3 && m == 0) return "R7";
        return (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    endfunction

    task automatic check_slot(int s, string force_tag);
        logic e;
        total++;
        e = (s < 2 || s > 4);
        if (lane_clk !== e) begin
            bad++;
            $display("FAIL R1 R2 clk slot%0d got=%b exp=%b", s, lane_clk, e);
        end
        for (int l = 0; l < 4; l++) begin
            string t;
            total++;
            e = exp_bit(l, s);
            t = (force_tag != "") ? force_tag : lane_tag(l, s);
            if (lane_data[l] !== e) begin
                bad++;
                $display("FAIL %s lane%0d slot%0d mode%0d got=%b exp=%b",
                         t, l, s, h_m, lane_data[l], e);
            end
        end
    endtask

    // Called at a negedge in slot 0; sends the held pixel and captures the next one.
    task automatic run_pixel(logic [7:0] nr, logic [7:0] ng, logic [7:0] nb,
                             logic nhs, logic nvs, logic nde, logic [1:0] nm,
                             bit noisy, string tag);
        for (int s = 0; s < 7; s++) begin
            if (noisy && s < 6) begin
                pix_r = 8'($urandom); pix_g = 8'($urandom); pix_b = 8'($urandom);
                pix_hsync = 1'($urandom); pix_vsync = 1'($urandom);
                pix_de = 1'($urandom); map_sel = 2'($urandom);
            end else begin
                pix_r = nr; pix_g = ng; pix_b = nb;
                pix_hsync = nhs; pix_vsync = nvs; pix_de = nde; map_sel = nm;
            end
            check_slot(s, tag);
            @(posedge clk);
            @(negedge clk);
        end
        h_r = nr; h_g = ng; h_b = nb; h_hs = nhs; h_vs = nvs; h_de = nde; h_m = nm;
    endtask

    task automatic rand_pixel(logic [1:0] m, bit noisy, string tag);
        run_pixel(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), m, noisy, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: first period after reset sends the cleared pixel
        run_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, "R9");
        // all four map selects: extremes then random pixels (R3 R4 R5 R6 R7)
        for (int m = 0; m < 4; m++) begin
            run_pixel(8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 2'(m), 1'b0, "");
            run_pixel(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 2'(m), 1'b0, "");
            for (int i = 0; i < 40; i++) rand_pixel(2'(m), 1'b0, "");
        end
        // R8: noise on inputs and mode except on the wrap slot
        for (int i = 0; i < 30; i++) rand_pixel(2'($urandom_range(0, 3)), 1'b1, "R8");
        // R9: reset part-way through a pixel
        rand_pixel(2'd1, 1'b0, "");
        repeat (3) begin @(posedge clk); @(negedge clk); end
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        total++;
        if (lane_data !== 4'd0 || lane_clk !== 1'b1) begin
            bad++;
            $display("FAIL R9 in reset got=%b/%b exp=0000/1", lane_data, lane_clk);
        end
        rst = 1'b0;
        h_r = '0; h_g = '0; h_b = '0; h_hs = 1'b0; h_vs = 1'b0; h_de = 1'b0; h_m = 2'd0;
        rand_pixel(2'd2, 1'b0, "R9");
        for (int i = 0; i < 5; i++) rand_pixel(2'd2, 1'b0, "");
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5 * 100000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule